// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is the control core of an electronic combination lock whose success depends on the order of dial operations, not merely on the set of values entered. Upstream logic delivers each completed dial operation as a turn direction and a dial number, qualified by a single-cycle valid strobe. The controller tracks how far the user has progressed through a fixed three-step secret and raises an open output once all three steps have arrived in order.

Progress is held in a two-bit state register with four states: idle, first step done, second step done, and open. Any valid operation that does not continue the secret sends the lock back to idle. The one exception is an operation equal to the first step, which restarts progress at "first step done". The open state is sticky. Further operations are ignored there until a relock pulse closes the lock. The secret is fixed by module parameters, with defaults of right 13, then left 22, then right 3.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While synchronous active-high `rst` is high at a clock edge, the lock is placed in idle, and `open_o` is 0 in the following cycle.
- R2: Three valid operations in order, namely right 13, then left 22, then right 3 (`op_right` = 1 means right, 0 means left), drive `open_o` to 1 in the cycle after the clock edge that accepts the third operation.
- R3: `open_o` depends on the registered state only. It is 1 only in the open state, and it rises only after an edge where `op_valid` was 1.
- R4: At an edge where `op_valid` is 0 and `relock` is 0, the state holds, and `op_right` and `op_num` have no effect.
- R5: A valid operation that is not the next expected step returns the lock to idle from any closed state. This includes dial numbers above 39.
- R6: A valid operation equal to the first step (right 13) puts the lock in the first-step-done state from any closed state, so the next operation left 22 continues the sequence.
- R7: In the open state, valid operations of any value are ignored, and `open_o` stays 1.
- R8: `relock` high at an edge returns the lock to idle. It takes priority over a valid operation presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe marking a completed dial operation |
| op_right | input | 1 | Turn direction: 1 right, 0 left |
| op_num | input | 6 | Dial number of the operation |
| relock | input | 1 | Close the lock and return to idle |
| open_o | output | 1 | Lock open (Moore output) |

## Verification
A wrong internal state surfaces at `open_o` in only two ways. A state wrongly at open shows up immediately as a high output. A state that has lost or invented progress stays hidden until the sequence is completed: the lock then opens one operation too early or too late, or fails to open at all. The stimulus therefore mixes correct next steps, restarts on the first step, wrong steps and idle cycles. It compares `open_o` against a reference state model after every clock edge, so any divergence is reported within the operation that completes or breaks the sequence.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int NUM_STEPS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
    } lock_regs_t;

endpackage

// File: rtl/lock_step_cmp.sv
module lock_step_cmp #(
    parameter int NUM_W = 6
) (
    input  logic             op_right,
    input  logic [NUM_W-1:0] op_num,
    input  logic             exp_right,
    input  logic [NUM_W-1:0] exp_num,
    output logic             hit
);
    always_comb begin
        hit = (op_right == exp_right) && (op_num == exp_num);
    end
endmodule

// File: rtl/lock_next.sv
module lock_next
    import lock_pkg::*;
(
    input  lock_state_e          cur,
    input  logic                 op_valid,
    input  logic                 relock,
    input  logic [NUM_STEPS-1:0] hit,
    output lock_state_e          nxt
);
    // Restart target for a valid op that does not continue the secret
    lock_state_e restart;

    always_comb begin
        restart = hit[0] ? ST_ONE : ST_IDLE;
        nxt     = cur;
        if (relock) begin
            nxt = ST_IDLE;
        end else if (op_valid) begin
            unique case (cur)
                ST_IDLE: nxt = restart;
                ST_ONE:  nxt = hit[1] ? ST_TWO  : restart;
                ST_TWO:  nxt = hit[2] ? ST_OPEN : restart;
                ST_OPEN: nxt = ST_OPEN;
                default: nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter int                          NUM_W     = 6,
    parameter logic [NUM_STEPS-1:0]        STEP_DIR  = 3'b101,
    parameter logic [NUM_STEPS*NUM_W-1:0]  STEP_NUM  = {6'd3, 6'd22, 6'd13}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_right,
    input  logic [NUM_W-1:0] op_num,
    input  logic             relock,
    output logic             open_o
);
    lock_regs_t            regs_d, regs_q;
    lock_state_e           nxt_state;
    lock_state_e           state_q;
    logic [NUM_STEPS-1:0]  hit;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        lock_step_cmp #(.NUM_W(NUM_W)) u_cmp (
            .op_right (op_right),
            .op_num   (op_num),
            .exp_right(STEP_DIR[i]),
            .exp_num  (STEP_NUM[i*NUM_W +: NUM_W]),
            .hit      (hit[i])
        );
    end

    lock_next u_next (
        .cur     (regs_q.state),
        .op_valid(op_valid),
        .relock  (relock),
        .hit     (hit),
        .nxt     (nxt_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{state: ST_IDLE};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_q = regs_q.state;
    assign open_o  = (state_q == ST_OPEN);

endmodule

// File: rtl/lock_chk.sv
module lock_chk
    import lock_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        relock,
    input logic        open_o,
    input lock_state_e state_q
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !open_o));

    // R3
    a_r3_open_after_op: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(op_valid));

    // R4
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(state_q));

    // R7
    a_r7_open_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN && !relock) |=> (state_q == ST_OPEN));

    // R8
    a_r8_relock_idle: assert property (@(posedge clk) disable iff (rst)
        relock |=> (state_q == ST_IDLE && !open_o));

    // R5 / R6: from idle a valid op reaches at most the first-step state
    a_r5_idle_progress: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && op_valid && !relock) |=>
            (state_q == ST_IDLE || state_q == ST_ONE));
endmodule

bind combo_lock_ctrl lock_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_valid(op_valid),
    .relock  (relock),
    .open_o  (open_o),
    .state_q (state_q)
);

// File: tb/tb_combo_lock_ctrl.sv
module tb_combo_lock_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_right = 1'b0;
    logic [5:0] op_num = '0;
    logic       relock = 1'b0;
    logic       open_o;

    int n_tests = 0;
    int n_fail  = 0;
    int mstate  = 0;   // reference: 0 idle, 1 one, 2 two, 3 open
    bit done    = 0;

    combo_lock_ctrl dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_right(op_right),
        .op_num(op_num), .relock(relock), .open_o(open_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_step(int k, bit d, int n);
        case (k)
            0: return d == 1'b1 && n == 13;
            1: return d == 1'b0 && n == 22;
            default: return d == 1'b1 && n == 3;
        endcase
    endfunction

    function automatic int model_next(int s, bit r, bit rl, bit v, bit d, int n);
        if (r || rl) return 0;
        if (!v) return s;
        if (s == 3) return 3;
        if (is_step(s, d, n)) return s + 1;
        if (is_step(0, d, n)) return 1;
        return 0;
    endfunction

    task automatic check(bit exp, string tag);
        n_tests++;
        if (open_o !== exp) begin
            n_fail++;
            $display("FAIL %s: open_o actual %b expected %b", tag, open_o, exp);
        end
    endtask

    task automatic cyc(bit r, bit rl, bit v, bit d, int n, string tag);
        @(negedge clk);
        rst = r; relock = rl; op_valid = v; op_right = d; op_num = 6'(n);
        @(posedge clk);
        #1;
        mstate = model_next(mstate, r, rl, v, d, n);
        check(mstate == 3, tag);
    endtask

    task automatic op(bit d, int n, string tag);
        cyc(0, 0, 1, d, n, tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, $urandom_range(1), $urandom_range(63), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset
        cyc(1, 0, 0, 0, 0, "R1 reset");
        cyc(1, 0, 1, 1, 13, "R1 reset with op");
        // R2 basic sequence, with idle gaps (R4)
        op(1, 13, "R2 step1");
        idle("R4 idle");
        op(0, 22, "R2 step2");
        idle("R4 idle noise");
        op(1, 3, "R2 step3 opens");
        // R7 ignored while open
        op(1, 40, "R7 ignore");
        op(0, 22, "R7 ignore");
        op(1, 13, "R7 ignore");
        // R8 relock with concurrent op
        cyc(0, 1, 1, 1, 3, "R8 relock priority");
        // R5 wrong steps
        op(1, 13, "R6 first");
        op(1, 22, "R5 wrong dir");
        op(0, 22, "R5 no progress");
        op(1, 3, "R5 stays closed");
        op(1, 13, "R6 first");
        op(0, 22, "R2 second");
        op(1, 45, "R5 out of range");
        op(1, 3, "R5 stays closed");
        // R6 restart from two and from one
        op(1, 13, "R6 a"); op(0, 22, "R6 b");
        op(1, 13, "R6 restart from two");
        op(0, 22, "R6 continue"); op(1, 3, "R6 opens");
        cyc(0, 1, 0, 0, 0, "R8 relock");
        op(1, 13, "R6 a"); op(1, 13, "R6 repeat first");
        op(0, 22, "R6 b"); op(1, 3, "R6 opens");
        cyc(1, 0, 0, 0, 0, "R1 reset from open");
        // R3 / R4 random mix
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(99);
            if (sel < 5) cyc(0, 1, $urandom_range(1), 1, 13, "R8 random relock");
            else if (sel < 20) idle("R4 random idle");
            else if (sel < 60 && mstate < 3) begin
                case (mstate)
                    0: op(1, 13, "R2 random step");
                    1: op(0, 22, "R2 random step");
                    default: op(1, 3, "R2 random step");
                endcase
            end else if (sel < 70) op(1, 13, "R6 random first");
            else op($urandom_range(1), $urandom_range(63), "R3 random op");
        end
        finish_run();
    end
endmodule